// File: doc/BRIEF.md
# Data Access Permission Fault Prioritizer

This block sits behind a data translation lookup that has already found a matching entry. It takes the attributes of the matched page, the kind of access, the requester's privilege and whether the access uses a no-fault address space. It then decides whether the access may proceed. A clean access returns a cacheability flag. A refused access returns exactly one fault, with a fault class and a reason code. Four page-permission checks are ranked in a fixed order, and only the winning fault is reported.

On any fault the block stores two things. The faulting virtual address and context go into a tag-access register. The direction, context type, page side-effect bit and address space identifier go into a fault-status record. Both registers hold their contents until the next fault. Every result appears exactly one clock after the request strobe.

The result port is a valid-only stream with no back-pressure. The consumer must accept `rsp_valid` in the cycle it is raised. A new request can be presented every cycle.

Top module: `dtlb_perm_fault`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0: `rsp_valid`, `rsp_fault`, `fault_class`, `fault_reason`, `rsp_uncacheable`, `tag_we`, `tag_data`, `sfsr_we` and `sfsr_data`.
- R2: A non-privileged access (`req_priv`=0) to a privileged page (`pg_priv`=1) always faults with `fault_class`=1 (access exception) and `fault_reason`=1 (privilege). No other check can override it.
- R3: If R2 does not apply, a write (`req_write`=1) to a page with `pg_writable`=0 faults with `fault_class`=2 (protection) and `fault_reason`=2 (other).
- R4: If neither R2 nor R3 applies, an access to a no-fault-only page (`pg_nofault`=1) with `req_nf_asi`=0 faults with `fault_class`=1 and `fault_reason`=4 (no-fault-only).
- R5: If none of R2 to R4 applies, an access to a side-effect page (`pg_sideeff`=1) with `req_nf_asi`=1 faults with `fault_class`=1 and `fault_reason`=3 (side-effect).
- R6: Each access reports at most one fault. When `rsp_fault`=0, both `fault_class` and `fault_reason` are 0.
- R7: On a fault response, `tag_we` pulses in the same cycle and `tag_data` becomes {`req_va`, `req_ctx`}, with the context in the low bits. On every other cycle `tag_data` keeps its value.
- R8: On a fault response, `sfsr_we` pulses and `sfsr_data` becomes {`req_asi`, `pg_sideeff`, `req_ctx_type`, `req_write`}, with `req_write` at bit 0. On every other cycle `sfsr_data` keeps its value.
- R9: `rsp_uncacheable` is 1 exactly when the response has no fault and the page has `pg_sideeff`=1.
- R10: `rsp_valid` is `req_valid` delayed by one clock. When `rsp_valid` is 0, `rsp_fault`, `fault_class`, `fault_reason`, `rsp_uncacheable`, `tag_we` and `sfsr_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | VA_W | Virtual address of the access |
| req_ctx | input | CTX_W | Context number of the access |
| req_ctx_type | input | 2 | Context type recorded on a fault |
| req_asi | input | ASI_W | Address space identifier |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Requester is privileged |
| req_nf_asi | input | 1 | Access uses a no-fault address space |
| pg_priv | input | 1 | Page is privileged-only |
| pg_writable | input | 1 | Page is writable |
| pg_nofault | input | 1 | Page is no-fault-only |
| pg_sideeff | input | 1 | Page has side effects |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access refused |
| fault_class | output | 2 | 0 none, 1 access exception, 2 protection |
| fault_reason | output | 3 | 0 none, 1 privilege, 2 other, 3 side-effect, 4 no-fault-only |
| rsp_uncacheable | output | 1 | Clean access must bypass caches |
| tag_we | output | 1 | Tag-access register written this cycle |
| tag_data | output | VA_W+CTX_W | Tag-access register contents |
| sfsr_we | output | 1 | Fault-status record written this cycle |
| sfsr_data | output | ASI_W+4 | Fault-status record contents |

## Verification
The hardest cases to reach are those where several faults apply at once. In such a case only the top-ranked one may be seen. The cases where a suppressed check would pick a different class are the most telling. For example, a user write to a read-only privileged page must report a privilege fault, not a protection fault. The stimulus covers every one of the 128 combinations of the seven decision inputs, so every overlap of conditions appears. Each request is followed by an idle cycle, which shows that both capture registers hold their contents when no fault occurs.

// File: rtl/dtlb_perm_pkg.sv
package dtlb_perm_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_ACCESS = 2'd1,
    CLS_PROT   = 2'd2
  } fault_cls_e;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_PRIV  = 3'd1,
    RSN_OTHER = 3'd2,
    RSN_SIDE  = 3'd3,
    RSN_NFO   = 3'd4
  } fault_rsn_e;

  // number of ranked permission checks
  localparam int unsigned NUM_CHECKS = 4;

  typedef struct packed {
    logic priv;
    logic writable;
    logic nofault;
    logic sideeff;
  } page_attr_t;

endpackage

// File: rtl/dtlb_perm_rank.sv
module dtlb_perm_rank
  import dtlb_perm_pkg::*;
(
  input  page_attr_t attr,
  input  logic       is_write,
  input  logic       is_priv,
  input  logic       nf_asi,
  output logic       fault,
  output logic [1:0] cls,
  output logic [2:0] rsn,
  output logic       uncache
);

  // index 0 is highest priority
  logic [NUM_CHECKS-1:0] hit;
  logic [1:0]            cls_tab [NUM_CHECKS];
  logic [2:0]            rsn_tab [NUM_CHECKS];

  assign hit[0] = !is_priv && attr.priv;
  assign hit[1] = is_write && !attr.writable;
  assign hit[2] = attr.nofault && !nf_asi;
  assign hit[3] = attr.sideeff && nf_asi;

  assign cls_tab[0] = CLS_ACCESS;
  assign rsn_tab[0] = RSN_PRIV;
  assign cls_tab[1] = CLS_PROT;
  assign rsn_tab[1] = RSN_OTHER;
  assign cls_tab[2] = CLS_ACCESS;
  assign rsn_tab[2] = RSN_NFO;
  assign cls_tab[3] = CLS_ACCESS;
  assign rsn_tab[3] = RSN_SIDE;

  always_comb begin
    cls = CLS_NONE;
    rsn = RSN_NONE;
    for (int k = NUM_CHECKS - 1; k >= 0; k--) begin
      if (hit[k]) begin
        cls = cls_tab[k];
        rsn = rsn_tab[k];
      end
    end
  end

  assign fault   = |hit;
  assign uncache = !fault && attr.sideeff;

endmodule

// File: rtl/dtlb_fault_capture.sv
module dtlb_fault_capture #(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned CTX_W = 13,
  parameter int unsigned ASI_W = 8,
  localparam int unsigned TAG_W = VA_W + CTX_W,
  localparam int unsigned SR_W  = ASI_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  input  logic [1:0]       ctx_type,
  input  logic [ASI_W-1:0] asi,
  input  logic             is_write,
  input  logic             sideeff,
  output logic             tag_we,
  output logic [TAG_W-1:0] tag_q,
  output logic             sr_we,
  output logic [SR_W-1:0]  sr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_we <= 1'b0;
      sr_we  <= 1'b0;
      tag_q  <= '0;
      sr_q   <= '0;
    end else begin
      tag_we <= cap_en;
      sr_we  <= cap_en;
      if (cap_en) begin
        tag_q <= {va, ctx};
        sr_q  <= {asi, sideeff, ctx_type, is_write};
      end
    end
  end

  // R8
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |-> $stable(sr_q));

endmodule

// File: rtl/dtlb_perm_fault.sv
module dtlb_perm_fault
  import dtlb_perm_pkg::*;
#(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned CTX_W = 13,
  parameter int unsigned ASI_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic [CTX_W-1:0]      req_ctx,
  input  logic [1:0]            req_ctx_type,
  input  logic [ASI_W-1:0]      req_asi,
  input  logic                  req_write,
  input  logic                  req_priv,
  input  logic                  req_nf_asi,
  input  logic                  pg_priv,
  input  logic                  pg_writable,
  input  logic                  pg_nofault,
  input  logic                  pg_sideeff,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [1:0]            fault_class,
  output logic [2:0]            fault_reason,
  output logic                  rsp_uncacheable,
  output logic                  tag_we,
  output logic [VA_W+CTX_W-1:0] tag_data,
  output logic                  sfsr_we,
  output logic [ASI_W+3:0]      sfsr_data
);

  page_attr_t attr;
  logic       d_fault;
  logic [1:0] d_cls;
  logic [2:0] d_rsn;
  logic       d_unc;

  assign attr = '{priv: pg_priv, writable: pg_writable,
                  nofault: pg_nofault, sideeff: pg_sideeff};

  dtlb_perm_rank u_rank (
    .attr     (attr),
    .is_write (req_write),
    .is_priv  (req_priv),
    .nf_asi   (req_nf_asi),
    .fault    (d_fault),
    .cls      (d_cls),
    .rsn      (d_rsn),
    .uncache  (d_unc)
  );

  dtlb_fault_capture #(.VA_W(VA_W), .CTX_W(CTX_W), .ASI_W(ASI_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (req_valid && d_fault),
    .va       (req_va),
    .ctx      (req_ctx),
    .ctx_type (req_ctx_type),
    .asi      (req_asi),
    .is_write (req_write),
    .sideeff  (pg_sideeff),
    .tag_we   (tag_we),
    .tag_q    (tag_data),
    .sr_we    (sfsr_we),
    .sr_q     (sfsr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_fault       <= 1'b0;
      fault_class     <= CLS_NONE;
      fault_reason    <= RSN_NONE;
      rsp_uncacheable <= 1'b0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_fault       <= req_valid && d_fault;
      fault_class     <= req_valid ? d_cls : CLS_NONE;
      fault_reason    <= req_valid ? d_rsn : RSN_NONE;
      rsp_uncacheable <= req_valid && d_unc;
    end
  end

  // R10
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  priv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && pg_priv) |=>
      (fault_class == CLS_ACCESS && fault_reason == RSN_PRIV));

  // R3
  prot_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv || !pg_priv) && req_write && !pg_writable) |=>
      (fault_class == CLS_PROT && fault_reason == RSN_OTHER));

  // R7
  tag_we_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we == rsp_fault);

  // R7
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_we |-> $stable(tag_data));

  // R9
  unc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncacheable |-> !rsp_fault);

  // R6
  no_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (fault_class == CLS_NONE && fault_reason == RSN_NONE));

endmodule

// File: tb/tb_dtlb_perm_fault.sv
`timescale 1ns/1ps
module tb_dtlb_perm_fault;
  localparam int VA_W = 48, CTX_W = 13, ASI_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_priv = 0, req_nf_asi = 0;
  logic pg_priv = 0, pg_writable = 0, pg_nofault = 0, pg_sideeff = 0;
  logic [VA_W-1:0] req_va = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [1:0] req_ctx_type = '0;
  logic [ASI_W-1:0] req_asi = '0;
  logic rsp_valid, rsp_fault, rsp_uncacheable, tag_we, sfsr_we;
  logic [1:0] fault_class;
  logic [2:0] fault_reason;
  logic [VA_W+CTX_W-1:0] tag_data;
  logic [ASI_W+3:0] sfsr_data;

  int n_run = 0, n_fail = 0;
  logic [VA_W+CTX_W-1:0] exp_tag = '0;
  logic [ASI_W+3:0] exp_sr = '0;

  always #2.5 clk = ~clk;

  dtlb_perm_fault #(.VA_W(VA_W), .CTX_W(CTX_W), .ASI_W(ASI_W)) dut (.*);

  task automatic chk(input logic ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({rsp_valid, rsp_fault, fault_class, fault_reason, rsp_uncacheable, tag_we, sfsr_we} == 0,
        "R1", {rsp_valid, rsp_fault, fault_class, fault_reason}, 0);
    chk(tag_data == 0 && sfsr_data == 0, "R1", tag_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0 && tag_data == 0, "R1", rsp_valid, 0);

    for (int i = 0; i < 128; i++) begin
      logic ep, ew, en, es, w, pr, nf, f;
      logic [1:0] ec;
      logic [2:0] er;
      {ep, ew, en, es, w, pr, nf} = 7'(i);
      req_valid = 1'b1;
      pg_priv = ep; pg_writable = ew; pg_nofault = en; pg_sideeff = es;
      req_write = w; req_priv = pr; req_nf_asi = nf;
      req_va = 48'h0000_1234_0000 + 48'(i) * 48'h0001_0003;
      req_ctx = 13'(i * 37 + 5);
      req_ctx_type = 2'(i);
      req_asi = 8'(i * 3 + 1);
      // reference priority model
      if (!pr && ep)      begin ec = 1; er = 1; end   // R2
      else if (w && !ew)  begin ec = 2; er = 2; end   // R3
      else if (en && !nf) begin ec = 1; er = 4; end   // R4
      else if (es && nf)  begin ec = 1; er = 3; end   // R5
      else                begin ec = 0; er = 0; end
      f = (ec != 0);
      if (f) begin
        exp_tag = {req_va, req_ctx};
        exp_sr  = {req_asi, es, req_ctx_type, w};
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1, "R10", rsp_valid, 1);
      if (!pr && ep) chk(fault_class == 1 && fault_reason == 1, "R2", {fault_class, fault_reason}, {ec, er});
      else if (w && !ew) chk(fault_class == 2 && fault_reason == 2, "R3", {fault_class, fault_reason}, {ec, er});
      else if (en && !nf) chk(fault_class == 1 && fault_reason == 4, "R4", {fault_class, fault_reason}, {ec, er});
      else if (es && nf) chk(fault_class == 1 && fault_reason == 3, "R5", {fault_class, fault_reason}, {ec, er});
      else chk(fault_class == 0 && fault_reason == 0, "R6", {fault_class, fault_reason}, 0);
      chk(rsp_fault == f, "R6", rsp_fault, f);
      chk(rsp_uncacheable == (!f && es), "R9", rsp_uncacheable, !f && es);
      chk(tag_we == f && tag_data == exp_tag, "R7", tag_data, exp_tag);
      chk(sfsr_we == f && sfsr_data == exp_sr, "R8", sfsr_data, exp_sr);
      @(negedge clk);
      // idle cycle: no response, captured state held
      chk(rsp_valid == 0 && rsp_fault == 0 && rsp_uncacheable == 0 && fault_class == 0,
          "R10", {rsp_valid, rsp_fault, rsp_uncacheable}, 0);
      chk(tag_we == 0 && tag_data == exp_tag, "R7", tag_data, exp_tag);
      chk(sfsr_we == 0 && sfsr_data == exp_sr, "R8", sfsr_data, exp_sr);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule